// File: doc/BRIEF.md
# Time-Base Interval Timer

This block is a free-running up-counter advanced by an oscillation-clock enable. A two-bit interval code picks one of four power-of-two periods. Each time the chosen period elapses, the block sets a sticky interval flag. The interrupt line is that flag qualified by an enable bit.

Software sees the block through one 16-bit control word. The word holds the interrupt enable, the interval flag, a counter-clear strobe and the interval code. The flag is cleared by writing 0 to its bit; writing 1 leaves it alone. The counter-clear bit clears the counter when written with 0 and always reads back as 1.

Three side-band pulses from the power and clock manager clear the flag when the device enters stop mode, when it moves from the sub clock to the main clock, and when it moves from the main clock to the PLL clock.

Top module: `tbase_timer`

## Requirements
- R1: After synchronous reset the enable is 0, the flag is 0, the interval code is 00, the counter is 0, `irq` is 0 and `reg_rdata` reads 16'h8400.
- R2: `reg_rdata` always returns 1 in bit 15 and bit 10, and 0 in bits 14:13 and 7:0. Bit 12 is the enable, bit 11 is the flag and bits 9:8 are the interval code.
- R3: The counter advances by one on each cycle with `osc_en` high and holds its value while `osc_en` is low.
- R4: Interval codes 00, 01, 10 and 11 select periods of 2^EXP0, 2^EXP1, 2^EXP2 and 2^EXP3 enabled cycles (defaults 12, 14, 16, 19). The flag sets on the enabled cycle in which the counter's low EXPn bits wrap to zero, and it reads 1 after that clock edge.
- R5: `irq` is high exactly when both the flag and the enable are 1.
- R6: A write with bit 11 = 0 clears the flag. A write with bit 11 = 1 leaves the flag unchanged.
- R7: A write with bit 10 = 0 clears every counter bit. A write with bit 10 = 1 leaves the counter running undisturbed.
- R8: A pulse on `stop_entry`, `sub_to_main` or `main_to_pll` clears the flag. It leaves the counter, the enable and the interval code unchanged.
- R9: When a counter-clear write coincides with an interval event, the counter clears and the flag is not set by that event.
- R10: When an interval event coincides with a flag-clear write or a mode pulse, the flag ends up set.
- R11: Every write loads the enable from bit 12 and the interval code from bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Counting enable, one pulse per oscillation-clock cycle |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| stop_entry | input | 1 | Pulse: entering stop mode |
| sub_to_main | input | 1 | Pulse: switch from sub clock to main clock |
| main_to_pll | input | 1 | Pulse: switch from main clock to PLL clock |
| reg_rdata | output | 16 | Read value of the control word |
| irq | output | 1 | Interval interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, an interval event meets a counter-clear write; in the other, it meets a flag clear. Both need the counter sitting exactly one enabled cycle before a wrap, and the counter cannot be read. The bench therefore first clears the counter with a write. It then counts exactly 2^EXP−1 enabled cycles, so the next enabled edge is known to carry the tap, and applies the colliding write or mode pulse on that edge. The counter's state after each collision is then inferred from the exact number of further cycles until the flag rises.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int unsigned WORD_W = 16;

    // control word bit positions (software decodes these)
    localparam int unsigned B_FIXED1 = 15;
    localparam int unsigned B_IE     = 12;
    localparam int unsigned B_FLAG   = 11;
    localparam int unsigned B_CLR    = 10;
    localparam int unsigned B_SEL_LO = 8;

    typedef struct packed {
        logic       ie;
        logic       flag;
        logic [1:0] sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ie: 1'b0, flag: 1'b0, sel: 2'b00};

    function automatic logic [WORD_W-1:0] pack_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w                     = '0;
        w[B_FIXED1]           = 1'b1;
        w[B_IE]               = c.ie;
        w[B_FLAG]             = c.flag;
        w[B_CLR]              = 1'b1;
        w[B_SEL_LO+1:B_SEL_LO] = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tbase_tap_sel.sv
module tbase_tap_sel #(
    parameter int unsigned CNT_W = 19,
    parameter int unsigned EXP0  = 12,
    parameter int unsigned EXP1  = 14,
    parameter int unsigned EXP2  = 16,
    parameter int unsigned EXP3  = 19
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             en,
    input  logic [1:0]       sel,
    output logic             tick
);
    localparam int unsigned EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

    logic [3:0] hit;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        // low EXPn bits all ones: next enabled step carries out of that tap
        assign hit[g] = &cnt[EXPS[g]-1:0];
    end

    assign tick = en & hit[sel];
endmodule

// File: rtl/tbase_ctrl_reg.sv
module tbase_ctrl_reg
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick,
    input  logic              mode_clr,
    output ctrl_t             ctrl,
    output logic              cnt_clr,
    output logic              set_evt,
    output logic [WORD_W-1:0] rdata
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    logic  flag_clr;
    logic  unused_wbits;

    assign cnt_clr  = wr & ~wdata[B_CLR];
    assign set_evt  = tick & ~cnt_clr;
    assign flag_clr = (wr & ~wdata[B_FLAG]) | mode_clr;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.ie  = wdata[B_IE];
            ctrl_d.sel = wdata[B_SEL_LO+1:B_SEL_LO];
        end
        if (set_evt)
            ctrl_d.flag = 1'b1;
        else if (flag_clr)
            ctrl_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl  = ctrl_q;
    assign rdata = pack_word(ctrl_q);
    assign unused_wbits = ^{wdata[15:13], wdata[7:0]};
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W = 19,
    parameter int unsigned EXP0  = 12,
    parameter int unsigned EXP1  = 14,
    parameter int unsigned EXP2  = 16,
    parameter int unsigned EXP3  = 19
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_en,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    input  logic        stop_entry,
    input  logic        sub_to_main,
    input  logic        main_to_pll,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             cnt_clr;
    logic             set_evt;
    logic             mode_clr;
    ctrl_t            ctrl_q;

    assign mode_clr = stop_entry | sub_to_main | main_to_pll;

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (osc_en),
        .clr (cnt_clr),
        .cnt (cnt_q)
    );

    tbase_tap_sel #(
        .CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
    ) u_tap (
        .cnt  (cnt_q),
        .en   (osc_en),
        .sel  (ctrl_q.sel),
        .tick (tick)
    );

    tbase_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .tick     (tick),
        .mode_clr (mode_clr),
        .ctrl     (ctrl_q),
        .cnt_clr  (cnt_clr),
        .set_evt  (set_evt),
        .rdata    (reg_rdata)
    );

    assign irq = ctrl_q.flag & ctrl_q.ie;
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
    parameter int unsigned CNT_W = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             osc_en,
    input logic             reg_wr,
    input logic [15:0]      reg_wdata,
    input logic             stop_entry,
    input logic             sub_to_main,
    input logic             main_to_pll,
    input logic [15:0]      reg_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             tick
);
    logic any_mode;
    assign any_mode = stop_entry | sub_to_main | main_to_pll;

    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15] && reg_rdata[10] && reg_rdata[14:13] == 2'b00 && reg_rdata[7:0] == 8'h00);

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (reg_rdata[12] && reg_rdata[11]));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en && !(reg_wr && !reg_wdata[10])) |=> cnt == $past(cnt) + CNT_W'(1));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !(reg_wr && !reg_wdata[10])) |=> $stable(cnt));

    // R7
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[10]) |=> cnt == '0);

    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[11] && !any_mode && !tick) |=> $stable(reg_rdata[11]));

    // R8
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (any_mode && !tick) |=> !reg_rdata[11]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !(reg_wr && !reg_wdata[10])) |=> reg_rdata[11]);

    // R9
    clr_blocks_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && reg_wr && !reg_wdata[10] && !reg_wdata[11]) |=> !reg_rdata[11]);
endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_en      (osc_en),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .stop_entry  (stop_entry),
    .sub_to_main (sub_to_main),
    .main_to_pll (main_to_pll),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .cnt         (cnt_q),
    .tick        (tick)
);

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int E0 = 2;
    localparam int E1 = 3;
    localparam int E2 = 5;
    localparam int E3 = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        stop_entry = 1'b0;
    logic        sub_to_main = 1'b0;
    logic        main_to_pll = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_timer #(.CNT_W(W), .EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3)) u_dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .stop_entry(stop_entry), .sub_to_main(sub_to_main), .main_to_pll(main_to_pll),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [15:0] wd(input logic ie, input logic fl, input logic clr, input logic [1:0] s);
        return {1'b1, 2'b00, ie, fl, clr, s, 8'h00};
    endfunction

    function automatic logic [15:0] rd(input logic ie, input logic fl, input logic [1:0] s);
        return {1'b1, 2'b00, ie, fl, 1'b1, s, 8'h00};
    endfunction

    function automatic int period(input int s);
        case (s)
            0: return 1 << E0;
            1: return 1 << E1;
            2: return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: inputs applied after a negedge, result observed at the next negedge
    task automatic cyc(input logic en, input logic wr, input logic [15:0] d, input logic [2:0] md);
        osc_en = en; reg_wr = wr; reg_wdata = d;
        stop_entry = md[0]; sub_to_main = md[1]; main_to_pll = md[2];
        @(negedge clk);
        osc_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        stop_entry = 1'b0; sub_to_main = 1'b0; main_to_pll = 1'b0;
    endtask

    task automatic write(input logic [15:0] d);
        cyc(1'b0, 1'b1, d, 3'b000);
    endtask

    task automatic run(input int n, input logic en);
        for (int i = 0; i < n; i++) cyc(en, 1'b0, '0, 3'b000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", 32'(reg_rdata), 32'h8400);
        check("R1 irq", 32'(irq), 0);

        // R4 R5 R11 R2: sweep every interval code with enable off and on
        for (int s = 0; s < 4; s++) begin
            for (int ie = 0; ie < 2; ie++) begin
                p = period(s);
                write(wd(ie[0], 1'b0, 1'b0, s[1:0]));
                check("R11 R2 readback", 32'(reg_rdata), 32'(rd(ie[0], 1'b0, s[1:0])));
                run(p - 1, 1'b1);
                check("R4 flag before period", 32'(reg_rdata[11]), 0);
                check("R5 irq before period", 32'(irq), 0);
                run(1, 1'b1);
                check("R4 flag at period", 32'(reg_rdata[11]), 1);
                check("R5 irq gate", 32'(irq), 32'(ie));
            end
        end

        p = period(1);
        // R3 hold while enable is low
        write(wd(1'b1, 1'b0, 1'b0, 2'd1));
        run(3, 1'b1);
        run(40, 1'b0);
        run(p - 4, 1'b1);
        check("R3 hold no early flag", 32'(reg_rdata[11]), 0);
        run(1, 1'b1);
        check("R3 flag after held count", 32'(reg_rdata[11]), 1);

        // R6 write 1 keeps flag, write 0 clears it
        write(wd(1'b1, 1'b1, 1'b1, 2'd1));
        check("R6 write 1 keeps flag", 32'(reg_rdata[11]), 1);
        write(wd(1'b1, 1'b0, 1'b1, 2'd1));
        check("R6 write 0 clears flag", 32'(reg_rdata[11]), 0);
        check("R5 irq off after clear", 32'(irq), 0);

        // R7 bit10=1 leaves counter, bit10=0 clears it (counter is 0 here)
        run(5, 1'b1);
        write(wd(1'b1, 1'b0, 1'b1, 2'd1));
        run(p - 6, 1'b1);
        check("R7 clr=1 no effect (early)", 32'(reg_rdata[11]), 0);
        run(1, 1'b1);
        check("R7 clr=1 no effect (flag)", 32'(reg_rdata[11]), 1);
        run(5, 1'b1);
        write(wd(1'b1, 1'b0, 1'b0, 2'd1));
        run(p - 1, 1'b1);
        check("R7 clr=0 restarts count", 32'(reg_rdata[11]), 0);
        run(1, 1'b1);
        check("R7 full period after clear", 32'(reg_rdata[11]), 1);

        // R8 each mode pulse clears only the flag (flag=1, counter=0 here)
        for (int m = 0; m < 3; m++) begin
            cyc(1'b0, 1'b0, '0, 3'(1 << m));
            check("R8 mode pulse clears flag", 32'(reg_rdata), 32'(rd(1'b1, 1'b0, 2'd1)));
            run(p - 1, 1'b1);
            check("R8 counter kept (early)", 32'(reg_rdata[11]), 0);
            run(1, 1'b1);
            check("R8 counter kept (flag)", 32'(reg_rdata[11]), 1);
        end

        // R9 counter clear collides with interval event
        write(wd(1'b1, 1'b0, 1'b0, 2'd1));
        run(p - 1, 1'b1);
        cyc(1'b1, 1'b1, wd(1'b1, 1'b1, 1'b0, 2'd1), 3'b000);
        check("R9 collision no flag", 32'(reg_rdata[11]), 0);
        run(p - 1, 1'b1);
        check("R9 counter cleared (early)", 32'(reg_rdata[11]), 0);
        run(1, 1'b1);
        check("R9 counter cleared (flag)", 32'(reg_rdata[11]), 1);

        // R10 flag-clear write collides with interval event
        write(wd(1'b1, 1'b0, 1'b1, 2'd1));
        run(p - 1, 1'b1);
        cyc(1'b1, 1'b1, wd(1'b1, 1'b0, 1'b1, 2'd1), 3'b000);
        check("R10 set beats write clear", 32'(reg_rdata[11]), 1);

        // R10 mode pulse collides with interval event
        write(wd(1'b1, 1'b0, 1'b1, 2'd1));
        run(p - 1, 1'b1);
        cyc(1'b1, 1'b0, '0, 3'b100);
        check("R10 set beats mode clear", 32'(reg_rdata[11]), 1);

        // R11 enable off through a write, code change readback
        write(wd(1'b0, 1'b1, 1'b1, 2'd2));
        check("R11 ie/sel reload", 32'(reg_rdata), 32'(rd(1'b0, 1'b1, 2'd2)));
        check("R5 irq masked", 32'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule